// File: doc/BRIEF.md
# Host Notify Receiver

This block sits in a system-management host. It answers as a bus target at the host's own 7-bit address so that a device which has taken the master role can report an event to it. It is fed by a byte-level target engine that reports start and stop conditions, the received address with its direction bit, and each received data byte. For every address and data byte the block gives the engine an acknowledge decision.

A notify frame is a write to the host address carrying three payload bytes and then a stop:

- a byte whose upper seven bits hold the address of the notifying device;
- the low byte of a 16-bit status word;
- the high byte of that status word.

Only a frame that reaches its stop with exactly these three bytes is accepted. The device address and the status word are then held in output registers and an interrupt is raised. The interrupt stays up until software pulses a clear. While an earlier notify is still pending, a new notify is refused at its first payload byte.

Top module: `notify_rx`

## Requirements
- R1: After reset, irq_o is 0, notify_dev_o is 0, notify_data_o is 0, and ack_o is 0 while no valid strobe is present.
- R2: In the cycle of addr_valid_i, ack_o is 1 only when addr_i equals HOST_ADDR and rw_i is 0 (write). A read (rw_i = 1) or any other address is not acknowledged.
- R3: In a frame whose address was acknowledged, each of the first three payload bytes is acknowledged in the cycle of its byte_valid_i, provided no notify is pending.
- R4: notify_dev_o takes bits 7:1 of the first payload byte of the accepted frame.
- R5: notify_data_o[7:0] takes the second payload byte and notify_data_o[15:8] takes the third payload byte.
- R6: irq_o and the new values appear in the cycle after the stop_i strobe of a frame that carried exactly three acknowledged payload bytes. irq_o stays 0 before that stop.
- R7: At stop, a frame with fewer than three payload bytes is discarded: irq_o stays 0 and the held values are unchanged.
- R8: A fourth payload byte is not acknowledged, and the whole frame is discarded at stop.
- R9: While irq_o is 1, the first payload byte of a new frame is not acknowledged, the frame is dropped, and the held values do not change.
- R10: A clear_i pulse lowers irq_o in the following cycle and leaves notify_dev_o and notify_data_o unchanged.
- R11: Payload bytes that follow an unacknowledged address are not acknowledged and never cause a notify.
- R12: A start condition in the middle of a frame discards the bytes collected so far. A following complete frame is accepted with its own values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or repeated start seen (one-cycle strobe) |
| stop_i | input | 1 | Stop seen (one-cycle strobe) |
| addr_valid_i | input | 1 | Address byte received (one-cycle strobe) |
| addr_i | input | 7 | Received target address |
| rw_i | input | 1 | Direction bit of the address byte, 1 = read |
| byte_valid_i | input | 1 | Data byte received (one-cycle strobe) |
| byte_i | input | 8 | Received data byte |
| ack_o | output | 1 | Acknowledge decision for the strobed byte, same cycle |
| clear_i | input | 1 | Software clear of the pending notify |
| irq_o | output | 1 | Notify pending interrupt |
| notify_dev_o | output | 7 | Address of the notifying device |
| notify_data_o | output | 16 | Status word of the notify |

## Verification
The acknowledge decision is combinational. It is due in the same cycle as its address or byte strobe, so the bench raises each strobe just after a falling edge and reads ack_o a few nanoseconds later, before the rising edge. The interrupt and the held values change one edge after the stop strobe, and irq_o falls one edge after a clear. The bench therefore reads them at the falling edge that follows the strobe's cycle, and also reads irq_o just before the stop to confirm that nothing appears early. Each discard case ends by reading the held values through the outputs, to show that the refused frame left no trace.

// File: rtl/notify_pkg.sv
package notify_pkg;
  parameter int ADDR_W = 7;
  parameter int DATA_W = 16;
  localparam int DATA_BYTES = DATA_W / 8;
  localparam int NBYTES = 1 + DATA_BYTES;
  localparam int CNT_W = $clog2(NBYTES + 1);

  typedef struct packed {
    logic [ADDR_W-1:0] dev;
    logic [DATA_W-1:0] data;
  } notify_t;
endpackage

// File: rtl/notify_frame.sv
module notify_frame
  import notify_pkg::*;
#(
  parameter logic [ADDR_W-1:0] HOST_ADDR = 7'h08
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rw_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              pending_i,
  output logic              ack_o,
  output logic              done_o,
  output notify_t           frame_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NBYTES);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       buf_q [NBYTES];
  logic             addr_hit, byte_take;

  assign addr_hit  = addr_valid_i && (addr_i == HOST_ADDR) && !rw_i;
  // first payload byte is refused while a notify is pending
  assign byte_take = byte_valid_i && active_q && (cnt_q != FULL)
                     && !((cnt_q == '0) && pending_i);
  assign ack_o     = addr_hit || byte_take;
  assign done_o    = stop_i && active_q && (cnt_q == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i || stop_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (addr_valid_i) begin
      active_q <= addr_hit;
      cnt_q    <= '0;
    end else if (byte_valid_i && active_q) begin
      if (byte_take) cnt_q <= cnt_q + CNT_W'(1);
      else           active_q <= 1'b0;
    end
  end

  for (genvar k = 0; k < NBYTES; k++) begin : g_buf
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  buf_q[k] <= '0;
      else if (byte_take && (cnt_q == CNT_W'(k)))  buf_q[k] <= byte_i;
    end
  end

  assign frame_o.dev = buf_q[0][7:8-ADDR_W];
  for (genvar k = 1; k < NBYTES; k++) begin : g_data
    assign frame_o.data[(k-1)*8 +: 8] = buf_q[k];
  end
endmodule

// File: rtl/notify_hold.sv
module notify_hold
  import notify_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    done_i,
  input  notify_t frame_i,
  input  logic    clear_i,
  output logic    irq_o,
  output notify_t held_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o  <= 1'b0;
      held_o <= '0;
    end else if (done_i) begin
      irq_o  <= 1'b1;
      held_o <= frame_i;
    end else if (clear_i) begin
      irq_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/notify_rx.sv
module notify_rx
  import notify_pkg::*;
#(
  parameter logic [6:0] HOST_ADDR = 7'h08
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        addr_valid_i,
  input  logic [6:0]  addr_i,
  input  logic        rw_i,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  output logic        ack_o,
  input  logic        clear_i,
  output logic        irq_o,
  output logic [6:0]  notify_dev_o,
  output logic [15:0] notify_data_o
);
  notify_t frame, held;
  logic    done;

  notify_frame #(.HOST_ADDR(HOST_ADDR)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .addr_valid_i (addr_valid_i),
    .addr_i       (addr_i),
    .rw_i         (rw_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .pending_i    (irq_o),
    .ack_o        (ack_o),
    .done_o       (done),
    .frame_o      (frame)
  );

  notify_hold u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (done),
    .frame_i (frame),
    .clear_i (clear_i),
    .irq_o   (irq_o),
    .held_o  (held)
  );

  assign notify_dev_o  = held.dev;
  assign notify_data_o = held.data;
endmodule

// File: rtl/notify_rx_checker.sv
module notify_rx_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        stop_i,
  input logic        addr_valid_i,
  input logic        rw_i,
  input logic        byte_valid_i,
  input logic        ack_o,
  input logic        clear_i,
  input logic        irq_o,
  input logic [6:0]  notify_dev_o,
  input logic [15:0] notify_data_o
);
  AST_ACK_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (addr_valid_i || byte_valid_i)); // R2
  AST_READ_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_i && rw_i) |-> !ack_o); // R2
  AST_IRQ_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o ##1 irq_o |-> $past(stop_i)); // R6
  AST_PENDING_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && byte_valid_i) |-> !ack_o); // R9
  AST_HELD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o ##1 irq_o |-> ($stable(notify_dev_o) && $stable(notify_data_o))); // R9
  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !stop_i) |=> !irq_o); // R10
endmodule

bind notify_rx notify_rx_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .stop_i        (stop_i),
  .addr_valid_i  (addr_valid_i),
  .rw_i          (rw_i),
  .byte_valid_i  (byte_valid_i),
  .ack_o         (ack_o),
  .clear_i       (clear_i),
  .irq_o         (irq_o),
  .notify_dev_o  (notify_dev_o),
  .notify_data_o (notify_data_o)
);

// File: tb/notify_rx_test.sv
module notify_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 0, stop = 0, addr_valid = 0, rw = 0, byte_valid = 0, clear = 0;
  logic [6:0]  addr = '0;
  logic [7:0]  data_byte = '0;
  logic        ack, irq;
  logic [6:0]  dev;
  logic [15:0] word;
  int nvec = 0, nerr = 0;
  bit done = 0;

  localparam logic [6:0] HOST = 7'h08;

  always #10 clk = ~clk;

  notify_rx #(.HOST_ADDR(HOST)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .addr_valid_i(addr_valid), .addr_i(addr), .rw_i(rw),
    .byte_valid_i(byte_valid), .byte_i(data_byte), .ack_o(ack),
    .clear_i(clear), .irq_o(irq), .notify_dev_o(dev), .notify_data_o(word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic do_addr(input logic [6:0] a, input logic r, input logic exp_ack, input string req);
    @(negedge clk); addr_valid = 1; addr = a; rw = r;
    #2 chk(req, 32'(ack), 32'(exp_ack));
    @(negedge clk); addr_valid = 0; rw = 0;
  endtask

  task automatic do_byte(input logic [7:0] b, input logic exp_ack, input string req);
    @(negedge clk); byte_valid = 1; data_byte = b;
    #2 chk(req, 32'(ack), 32'(exp_ack));
    @(negedge clk); byte_valid = 0;
  endtask

  // stop strobe; results are read at the next falling edge
  task automatic do_stop();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
  endtask

  task automatic t_reset();
    chk("R1 irq", 32'(irq), 0);
    chk("R1 dev", 32'(dev), 0);
    chk("R1 data", 32'(word), 0);
    chk("R1 ack idle", 32'(ack), 0);
  endtask

  task automatic t_good();
    do_start();
    do_addr(HOST, 0, 1, "R2 host write ack");
    do_byte(8'h5A, 1, "R3 dev byte ack");
    do_byte(8'h34, 1, "R3 low byte ack");
    do_byte(8'h12, 1, "R3 high byte ack");
    chk("R6 no irq before stop", 32'(irq), 0);
    do_stop();
    chk("R6 irq after stop", 32'(irq), 1);
    chk("R4 dev", 32'(dev), 32'h2D);
    chk("R5 data", 32'(word), 32'h1234);
  endtask

  task automatic t_pending();
    do_start();
    do_addr(HOST, 0, 1, "R9 addr ack");
    do_byte(8'h40, 0, "R9 first byte nack");
    do_byte(8'h77, 0, "R9 next byte nack");
    do_stop();
    chk("R9 irq held", 32'(irq), 1);
    chk("R9 dev kept", 32'(dev), 32'h2D);
    chk("R9 data kept", 32'(word), 32'h1234);
  endtask

  task automatic t_clear();
    do_clear();
    chk("R10 irq low", 32'(irq), 0);
    chk("R10 dev kept", 32'(dev), 32'h2D);
    chk("R10 data kept", 32'(word), 32'h1234);
  endtask

  task automatic t_short();
    do_start();
    do_addr(HOST, 0, 1, "R7 addr ack");
    do_byte(8'h10, 1, "R7 b0 ack");
    do_byte(8'h99, 1, "R7 b1 ack");
    do_stop();
    chk("R7 irq stays low", 32'(irq), 0);
    chk("R7 data kept", 32'(word), 32'h1234);
  endtask

  task automatic t_long();
    do_start();
    do_addr(HOST, 0, 1, "R8 addr ack");
    do_byte(8'h22, 1, "R8 b0 ack");
    do_byte(8'hAA, 1, "R8 b1 ack");
    do_byte(8'hBB, 1, "R8 b2 ack");
    do_byte(8'hCC, 0, "R8 fourth byte nack");
    do_stop();
    chk("R8 irq stays low", 32'(irq), 0);
    chk("R8 dev kept", 32'(dev), 32'h2D);
  endtask

  task automatic t_other();
    do_start();
    do_addr(7'h33, 0, 0, "R2 other addr nack");
    for (int i = 0; i < 3; i++) do_byte(8'(8'h61 + i), 0, "R11 byte nack");
    do_stop();
    chk("R11 irq low", 32'(irq), 0);
    do_start();
    do_addr(HOST, 1, 0, "R2 host read nack");
    do_byte(8'h44, 0, "R11 byte after read nack");
    do_stop();
    chk("R11 irq low after read", 32'(irq), 0);
    chk("R11 data kept", 32'(word), 32'h1234);
  endtask

  task automatic t_restart();
    do_start();
    do_addr(HOST, 0, 1, "R12 addr ack");
    do_byte(8'h02, 1, "R12 b0 ack");
    do_byte(8'h03, 1, "R12 b1 ack");
    do_start();
    do_addr(HOST, 0, 1, "R12 readdr ack");
    do_byte(8'h3C, 1, "R12 new b0 ack");
    do_byte(8'hEF, 1, "R12 new b1 ack");
    do_byte(8'hBE, 1, "R12 new b2 ack");
    do_stop();
    chk("R12 irq", 32'(irq), 1);
    chk("R12 dev", 32'(dev), 32'h1E);
    chk("R12 data", 32'(word), 32'hBEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_good();
    t_pending();
    t_clear();
    t_short();
    t_long();
    t_other();
    t_restart();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nvec++; nerr++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule